// File: doc/BRIEF.md
# Base and limit relocation unit

This unit sits between a requester and physical memory. It relocates and range-checks each memory reference using a single base register and a single limit register. When the requester is in user mode, a logical address arriving with a request strobe is checked against the limit, and the base is added to it. If the address is legal, the sum goes out as a physical memory request. If it is not, a protection fault is raised instead and no memory request is issued. In privileged mode a request bypasses relocation and checking, so the privileged requester can reach every physical address.

The two registers are loaded through a small write port that works only while the privileged input is high. A write attempted in user mode leaves both registers untouched and raises a privilege-violation pulse. Both register values are always visible on readback outputs. During a context switch, the outgoing values can be saved and the incoming ones loaded before the requester returns to user mode. The range compare and the base addition are evaluated side by side in the same cycle. Every result appears one clock after its request.

Top module: `blr_unit`

## Requirements
- R1: After reset, base and limit read back as zero, mem_req_o, fault_o and priv_viol_o are low, and any user-mode request faults until the registers are loaded.
- R2: A user-mode request whose logical address is strictly less than the limit produces mem_req_o high with mem_addr_o equal to base plus logical address, one cycle after the request.
- R3: A user-mode request whose logical address is greater than or equal to the limit produces a one-cycle fault_o pulse, mem_req_o low and mem_addr_o zero, one cycle after the request.
- R4: A user-mode request where base plus logical address does not fit in ADDR_W bits faults exactly as in R3, even if the address is below the limit.
- R5: A privileged-mode request produces mem_req_o with mem_addr_o equal to the unmodified logical address, and never faults, whatever the base and limit hold.
- R6: A register write with priv_i high updates the register chosen by reg_sel_i (0 selects base, taking the low ADDR_W bits of reg_wdata_i; 1 selects limit, taking all ADDR_W+1 bits). The new value appears on base_o or limit_o after the clock edge, and a request in the same cycle still uses the old values.
- R7: A register write with priv_i low changes neither register and produces a one-cycle priv_viol_o pulse one cycle later. A user request in the same cycle is translated normally.
- R8: Requests on consecutive cycles each produce their own result one cycle later, with no stall.
- R9: A cycle with req_vld_i low produces mem_req_o low, fault_o low and mem_addr_o zero one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv_i | input | 1 | Privileged mode when high |
| req_vld_i | input | 1 | Request strobe |
| req_addr_i | input | ADDR_W | Logical address (physical address in privileged mode) |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 selects base, 1 selects limit |
| reg_wdata_i | input | ADDR_W+1 | Register write data |
| base_o | output | ADDR_W | Base register readback |
| limit_o | output | ADDR_W+1 | Limit register readback |
| mem_req_o | output | 1 | Physical memory request, registered |
| mem_addr_o | output | ADDR_W | Physical address, zero when no request |
| fault_o | output | 1 | One-cycle protection fault pulse |
| priv_viol_o | output | 1 | One-cycle pulse on a user-mode register write |

## Verification
The assertions assume that priv_i, req_vld_i and the write port are stable across each rising edge. They also assume that a request's mode is the priv_i level sampled in that same cycle. The stimulus meets this by changing every input only on the falling edge, and by holding each mode for a whole cycle. The embedded properties also take for granted that a privileged request carries an address the memory accepts without checking. For that reason the stimulus mixes privileged requests with arbitrary base and limit contents, and never expects a fault from them.

// File: rtl/blr_pkg.sv
package blr_pkg;

    // register selector on the write port
    typedef enum logic {
        SEL_BASE  = 1'b0,
        SEL_LIMIT = 1'b1
    } blr_sel_e;

endpackage

// File: rtl/blr_regs.sv
module blr_regs
    import blr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              priv_i,
    input  logic              we_i,
    input  logic              sel_i,
    input  logic [ADDR_W:0]   wdata_i,
    output logic [ADDR_W-1:0] base_o,
    output logic [ADDR_W:0]   limit_o,
    output logic              viol_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W:0]   limit;
        logic              viol;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.viol = we_i && !priv_i;
        if (we_i && priv_i) begin
            if (blr_sel_e'(sel_i) == SEL_BASE) begin
                st_d.base = wdata_i[ADDR_W-1:0];
            end else begin
                st_d.limit = wdata_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign base_o  = st_q.base;
    assign limit_o = st_q.limit;
    assign viol_o  = st_q.viol;

    // R7: a user-mode write leaves both registers as they were
    p_user_write_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !priv_i) |=> ($stable(base_o) && $stable(limit_o)));

    // R7: a user-mode write is flagged in the next cycle
    p_user_write_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !priv_i) |=> viol_o);

    // R6: without a privileged write the registers keep their values
    p_no_write_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_i && priv_i) |=> ($stable(base_o) && $stable(limit_o)));

endmodule

// File: rtl/blr_xlate.sv
module blr_xlate #(
    parameter int ADDR_W      = 16,
    parameter bit CARRY_FAULT = 1'b1
) (
    input  logic              priv_i,
    input  logic [ADDR_W-1:0] laddr_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W:0]   limit_i,
    output logic              legal_o,
    output logic [ADDR_W-1:0] paddr_o
);

    localparam int SUM_W = ADDR_W + 1;

    logic [SUM_W-1:0] sum;
    logic             below_limit;
    logic             fits;

    // compare and add share no path: both evaluated in parallel
    assign sum         = {1'b0, base_i} + {1'b0, laddr_i};
    assign below_limit = {1'b0, laddr_i} < limit_i;

    generate
        if (CARRY_FAULT) begin : g_carry_chk
            assign fits = !sum[SUM_W-1];
        end else begin : g_carry_wrap
            assign fits = 1'b1;
        end
    endgenerate

    assign legal_o = priv_i || (below_limit && fits);
    assign paddr_o = priv_i ? laddr_i : sum[ADDR_W-1:0];

endmodule

// File: rtl/blr_unit.sv
module blr_unit
    import blr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              priv_i,
    input  logic              req_vld_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic              reg_we_i,
    input  logic              reg_sel_i,
    input  logic [ADDR_W:0]   reg_wdata_i,
    output logic [ADDR_W-1:0] base_o,
    output logic [ADDR_W:0]   limit_o,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              fault_o,
    output logic              priv_viol_o
);

    typedef struct packed {
        logic              req;
        logic              fault;
        logic [ADDR_W-1:0] addr;
    } out_t;

    out_t out_d, out_q;

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W:0]   limit_q;
    logic              legal;
    logic [ADDR_W-1:0] paddr;

    blr_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .priv_i  (priv_i),
        .we_i    (reg_we_i),
        .sel_i   (reg_sel_i),
        .wdata_i (reg_wdata_i),
        .base_o  (base_q),
        .limit_o (limit_q),
        .viol_o  (priv_viol_o)
    );

    blr_xlate #(.ADDR_W(ADDR_W), .CARRY_FAULT(1'b1)) u_xlate (
        .priv_i  (priv_i),
        .laddr_i (req_addr_i),
        .base_i  (base_q),
        .limit_i (limit_q),
        .legal_o (legal),
        .paddr_o (paddr)
    );

    always_comb begin
        out_d = '0;
        if (req_vld_i) begin
            out_d.req   = legal;
            out_d.fault = !legal;
            out_d.addr  = legal ? paddr : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign base_o     = base_q;
    assign limit_o    = limit_q;
    assign mem_req_o  = out_q.req;
    assign mem_addr_o = out_q.addr;
    assign fault_o    = out_q.fault;

    // R3: a fault never comes with a memory request
    p_fault_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req_o && fault_o));

    // R8: every request yields exactly one outcome next cycle
    p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld_i |=> (mem_req_o ^ fault_o));

    // R9: an idle cycle produces nothing
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld_i |=> (!mem_req_o && !fault_o && mem_addr_o == '0));

    // R5: privileged requests pass through unchanged
    p_priv_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld_i && priv_i) |=> (mem_req_o && mem_addr_o == $past(req_addr_i)));

    // R3: a user address at or above the limit faults
    p_over_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld_i && !priv_i && {1'b0, req_addr_i} >= limit_o) |=> fault_o);

endmodule

// File: tb/blr_unit_bench.sv
`timescale 1ns/1ps
module blr_unit_bench;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          priv_i = 1'b0;
    logic          req_vld_i = 1'b0;
    logic [AW-1:0] req_addr_i = '0;
    logic          reg_we_i = 1'b0;
    logic          reg_sel_i = 1'b0;
    logic [AW:0]   reg_wdata_i = '0;
    logic [AW-1:0] base_o;
    logic [AW:0]   limit_o;
    logic          mem_req_o;
    logic [AW-1:0] mem_addr_o;
    logic          fault_o;
    logic          priv_viol_o;

    always #2.5 clk = ~clk;

    blr_unit #(.ADDR_W(AW)) u_blr_unit (
        .clk(clk), .rst_n(rst_n), .priv_i(priv_i), .req_vld_i(req_vld_i),
        .req_addr_i(req_addr_i), .reg_we_i(reg_we_i), .reg_sel_i(reg_sel_i),
        .reg_wdata_i(reg_wdata_i), .base_o(base_o), .limit_o(limit_o),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .fault_o(fault_o),
        .priv_viol_o(priv_viol_o)
    );

    typedef struct {
        logic          req;
        logic          fault;
        logic [AW-1:0] addr;
        logic          viol;
        logic [AW-1:0] base;
        logic [AW:0]   limit;
        string         tag;
    } item_t;

    item_t         sb_q[$];
    int            n_cmp = 0;
    int            n_bad = 0;
    logic [AW-1:0] base_m = '0;
    logic [AW:0]   limit_m = '0;
    bit            done = 1'b0;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // driver: applies one cycle of stimulus and pushes the expected result
    task automatic step(input logic p, input logic rv, input logic [AW-1:0] ra,
                        input logic we, input logic sel, input logic [AW:0] wd,
                        input string tag);
        item_t it;
        logic [AW:0] sum;
        @(negedge clk);
        priv_i = p; req_vld_i = rv; req_addr_i = ra;
        reg_we_i = we; reg_sel_i = sel; reg_wdata_i = wd;
        sum = {1'b0, base_m} + {1'b0, ra};
        it.req = 1'b0; it.fault = 1'b0; it.addr = '0; it.tag = tag;
        if (rv) begin
            if (p) begin
                it.req = 1'b1; it.addr = ra;
            end else if (({1'b0, ra} < limit_m) && !sum[AW]) begin
                it.req = 1'b1; it.addr = sum[AW-1:0];
            end else begin
                it.fault = 1'b1;
            end
        end
        it.viol = we && !p;
        if (we && p) begin
            if (sel) limit_m = wd;
            else     base_m  = wd[AW-1:0];
        end
        it.base  = base_m;
        it.limit = limit_m;
        sb_q.push_back(it);
    endtask

    // monitor: compares one cycle after each push, away from the edge
    always begin
        @(posedge clk);
        #1;
        if (sb_q.size() > 0) begin
            item_t e;
            e = sb_q.pop_front();
            chk(e.tag, "mem_req", 32'(mem_req_o), 32'(e.req));
            chk(e.tag, "fault", 32'(fault_o), 32'(e.fault));
            chk(e.tag, "mem_addr", 32'(mem_addr_o), 32'(e.addr));
            chk(e.tag, "priv_viol", 32'(priv_viol_o), 32'(e.viol));
            chk(e.tag, "base", 32'(base_o), 32'(e.base));
            chk(e.tag, "limit", 32'(limit_o), 32'(e.limit));
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", "base", 32'(base_o), 32'h0);
        chk("R1", "limit", 32'(limit_o), 32'h0);
        chk("R1", "mem_req", 32'(mem_req_o), 32'h0);
        chk("R1", "fault", 32'(fault_o), 32'h0);
        chk("R1", "priv_viol", 32'(priv_viol_o), 32'h0);
        rst_n = 1'b1;

        step(0, 1, 16'h0000, 0, 0, '0, "R1");          // limit zero: faults
        step(0, 1, 16'h0005, 0, 0, '0, "R1");
        step(0, 0, 16'h0000, 1, 0, 17'h01000, "R7");   // user write base
        step(0, 0, 16'h0000, 1, 1, 17'h00100, "R7");   // user write limit
        step(1, 0, 16'h0000, 1, 0, 17'h01000, "R6");   // base = 0x1000
        step(1, 1, 16'h0042, 1, 1, 17'h00100, "R6");   // limit, req bypasses
        step(1, 1, 16'h1234, 0, 0, '0, "R5");
        step(1, 1, 16'hFFFF, 0, 0, '0, "R5");
        step(0, 1, 16'h0000, 0, 0, '0, "R2");
        step(0, 1, 16'h00FF, 0, 0, '0, "R2");          // last legal
        step(0, 1, 16'h0100, 0, 0, '0, "R3");          // equal to limit
        step(0, 1, 16'hFFFF, 0, 0, '0, "R3");
        step(0, 0, 16'h0000, 0, 0, '0, "R9");
        step(0, 1, 16'h0010, 1, 0, 17'h00000, "R7");   // user write + request
        step(0, 1, 16'h0011, 0, 0, '0, "R8");          // back to back
        step(0, 1, 16'h0200, 0, 0, '0, "R8");
        step(0, 1, 16'h0012, 0, 0, '0, "R8");
        step(1, 0, 16'h0000, 1, 0, 17'h0FF80, "R6");   // base near top
        step(1, 0, 16'h0000, 1, 1, 17'h00200, "R6");
        step(0, 1, 16'h007F, 0, 0, '0, "R4");          // sum = 0xFFFF
        step(0, 1, 16'h0080, 0, 0, '0, "R4");          // carries out
        step(1, 0, 16'h0000, 1, 0, 17'h00000, "R6");
        step(1, 0, 16'h0000, 1, 1, 17'h10000, "R6");   // full-size limit
        step(0, 1, 16'hFFFF, 0, 0, '0, "R2");
        step(1, 1, 16'h0000, 1, 1, 17'h00000, "R6");   // limit back to zero
        step(0, 1, 16'h0000, 0, 0, '0, "R3");
        step(0, 0, 16'h0000, 0, 0, '0, "R9");
        step(0, 0, 16'h0000, 0, 0, '0, "R9");
        @(posedge clk);
        #2;
        done = 1'b1;
        summary();
        $finish;
    end

endmodule